// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a dual-clock FIFO for 18-bit words. It has a power-of-two depth that is set by a parameter. Writes are taken on the write clock and reads on the read clock. The read and write pointers cross between the two clock domains as Gray code through two-flop synchronisers.

Five status outputs are derived from the number of words held in the storage array:
- full (standard mode) or input-ready (fall-through mode);
- empty (standard mode) or output-ready (fall-through mode);
- half-full;
- programmable almost-full;
- programmable almost-empty.

A static mode input picks the output timing:
- **Standard mode.** A read request moves the next word to the data output.
- **First-word-fall-through mode.** The oldest word is presented at the output without any request. That presented word is no longer counted as a word in memory, so every flag threshold moves by one write.

Two offset registers set the almost-full and almost-empty thresholds. At master reset they load one of two default values, chosen by a select pin. After that they can be rewritten through a parallel load port that runs on the write clock. A separate partial reset empties the FIFO but keeps the programmed offsets.

Top module: `prog_flag_fifo`

## Requirements
- R1: After master reset the FIFO is empty and the flags take these values:
  - standard mode: full_ir_o=1, ef_or_o=0, hf_n_o=1, paf_n_o=1, pae_n_o=0;
  - fall-through mode: full_ir_o=0 and ef_or_o=1, with the other flags as in standard mode.
- R2: In standard mode, a read request while memory holds data makes dout_o show the oldest word after the next read-clock edge. Words leave in the order they were written.
- R3: In fall-through mode, the first word written into an empty FIFO appears on dout_o without a read request, and ef_or_o goes low. dout_o holds that word until a read request consumes it.
- R4: In standard mode, full_ir_o goes low once memory holds DEPTH words. Writes while full are ignored and leave the stored contents unchanged.
- R5: A read request is ignored while no data is available (ef_or_o low in standard mode, high in fall-through mode). dout_o and the flags are then unchanged.
- R6: paf_n_o is low exactly when memory holds at least DEPTH-m words, where m is the full offset. It responds two write-clock edges after the write that crosses the threshold.
- R7: pae_n_o is low while memory holds n words or fewer, and high from n+1 words upward, where n is the empty offset.
- R8: hf_n_o is low exactly when memory holds more than DEPTH/2 words.
- R9: Master reset loads both offsets with DFLT_LO when ld_sel_i is 0, and with DFLT_HI when ld_sel_i is 1.
- R10: A write-clock edge with ofs_wr_i=1 loads ofs_data_i into one offset register: the full offset when ofs_sel_i=0, the empty offset when ofs_sel_i=1. Any value from 0 to DEPTH-1 is accepted.
- R11: A low level on prst_ni empties the FIFO and returns the flags to their R1 values. The programmed offsets are kept.
- R12: In fall-through mode, the word on the output register is not counted. The FIFO therefore takes DEPTH+1 words before input-ready (full_ir_o) goes high, and paf_n_o falls after DEPTH+1-m writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| prst_ni | input | 1 | Partial reset, active low, asynchronous; keeps offsets |
| fwft_i | input | 1 | 1 = first-word-fall-through mode, 0 = standard mode; static |
| ld_sel_i | input | 1 | Picks the default offsets at master reset |
| wen_i | input | 1 | Write request |
| din_i | input | W | Write data |
| ofs_wr_i | input | 1 | Offset load strobe (write clock) |
| ofs_sel_i | input | 1 | 0 = full offset, 1 = empty offset |
| ofs_data_i | input | log2(DEPTH) | Offset value to load |
| ren_i | input | 1 | Read request |
| dout_o | output | W | Read data / output register |
| full_ir_o | output | 1 | Full, active low (standard mode); input-ready, active low (fall-through mode) |
| ef_or_o | output | 1 | Empty, active low (standard mode); output-ready, active low (fall-through mode) |
| hf_n_o | output | 1 | Half-full, active low |
| paf_n_o | output | 1 | Almost-full, active low |
| pae_n_o | output | 1 | Almost-empty, active low |

## Verification
A wrong word count shows up as a flag that switches one write early or late. The bench sweeps the fill level one word at a time and checks every flag once both synchronisers have settled, so an off-by-one in any threshold is caught at the first level where it differs. A corrupted pointer or output register shows up at dout_o on the very next read, because each read is compared with a queue model of the stored words. A lost or extra pipeline stage on the almost-full path is caught by checking paf_n_o on each of the two write-clock edges after the crossing write. Offsets that are lost on partial reset, or loaded into the wrong register, move a threshold; this is visible within one sweep.

// File: rtl/prog_flag_fifo_pkg.sv
package prog_flag_fifo_pkg;

  typedef enum logic {
    OFS_FULL  = 1'b0,
    OFS_EMPTY = 1'b1
  } ofs_sel_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/prog_fifo_sync.sv
module prog_fifo_sync #(
  parameter int PW     = 11,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);

  logic [STAGES-1:0][PW-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/prog_fifo_wr.sv
module prog_fifo_wr
  import prog_flag_fifo_pkg::*;
#(
  parameter  int DEPTH   = 1024,
  parameter  int DFLT_LO = 127,
  parameter  int DFLT_HI = 1023,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_i,
  input  logic          ld_sel_i,
  input  logic          wen_i,
  input  logic          ofs_wr_i,
  input  logic          ofs_sel_i,
  input  logic [AW-1:0] ofs_data_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic [AW-1:0] waddr_o,
  output logic          mem_we_o,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] empty_ofs_o,
  output logic          full_ir_o,
  output logic          hf_n_o,
  output logic          paf_n_o
);

  localparam int CW = PW + 1;

  logic          arst_n;
  logic [PW-1:0] wptr_q, wgray_q, rsync_bin, wcnt, wptr_nxt;
  logic          full, do_wr, paf_hit;
  logic [AW-1:0] full_ofs_q, empty_ofs_q;
  logic          paf_s1_q, paf_s2_q;
  logic [CW-1:0] paf_sum;

  assign arst_n    = rst_ni & prst_ni;
  assign rsync_bin = PW'(gray2bin(32'(rgray_sync_i)));
  assign wcnt      = wptr_q - rsync_bin;
  assign full      = (wcnt == PW'(DEPTH));
  assign do_wr     = wen_i & ~full;
  assign wptr_nxt  = wptr_q + PW'(1);

  always_ff @(posedge wclk_i or negedge arst_n) begin
    if (!arst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (do_wr) begin
      wptr_q  <= wptr_nxt;
      wgray_q <= PW'(bin2gray(32'(wptr_nxt)));
    end
  end

  // offsets survive partial reset; defaults picked at master reset
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_ofs_q  <= ld_sel_i ? AW'(DFLT_HI) : AW'(DFLT_LO);
      empty_ofs_q <= ld_sel_i ? AW'(DFLT_HI) : AW'(DFLT_LO);
    end else if (ofs_wr_i) begin
      if (ofs_sel_i == OFS_EMPTY) empty_ofs_q <= ofs_data_i;
      else                        full_ofs_q  <= ofs_data_i;
    end
  end

  assign paf_sum = {1'b0, wcnt} + CW'(full_ofs_q);
  assign paf_hit = (paf_sum >= CW'(DEPTH));

  always_ff @(posedge wclk_i or negedge arst_n) begin
    if (!arst_n) begin
      paf_s1_q <= 1'b1;
      paf_s2_q <= 1'b1;
    end else begin
      paf_s1_q <= ~paf_hit;
      paf_s2_q <= paf_s1_q;
    end
  end

  assign waddr_o     = wptr_q[AW-1:0];
  assign mem_we_o    = do_wr;
  assign wgray_o     = wgray_q;
  assign empty_ofs_o = empty_ofs_q;
  assign full_ir_o   = fwft_i ? full : ~full;
  assign hf_n_o      = ~(wcnt > PW'(DEPTH / 2));
  assign paf_n_o     = paf_s2_q;

  // R4
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!arst_n)
    (wen_i && full) |=> $stable(wptr_q));

  // R4
  wcnt_range_chk: assert property (@(posedge wclk_i) disable iff (!arst_n)
    wcnt <= PW'(DEPTH));

endmodule

// File: rtl/prog_fifo_rd.sv
module prog_fifo_rd
  import prog_flag_fifo_pkg::*;
#(
  parameter  int W     = 18,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_i,
  input  logic          ren_i,
  input  logic [PW-1:0] wgray_sync_i,
  input  logic [AW-1:0] empty_ofs_i,
  input  logic [W-1:0]  rd_data_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic [W-1:0]  dout_o,
  output logic          ef_or_o,
  output logic          pae_n_o
);

  logic          arst_n;
  logic [PW-1:0] rptr_q, rgray_q, wsync_bin, rcnt, rptr_nxt;
  logic          has, pop, ov_q;
  logic [W-1:0]  dout_q;

  assign arst_n    = rst_ni & prst_ni;
  assign wsync_bin = PW'(gray2bin(32'(wgray_sync_i)));
  assign rcnt      = wsync_bin - rptr_q;
  assign has       = (rcnt != '0);
  assign rptr_nxt  = rptr_q + PW'(1);
  // fall-through refills the output register whenever it is free or being consumed
  assign pop       = fwft_i ? (has & (~ov_q | ren_i)) : (ren_i & has);

  always_ff @(posedge rclk_i or negedge arst_n) begin
    if (!arst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
    end else if (pop) begin
      rptr_q  <= rptr_nxt;
      rgray_q <= PW'(bin2gray(32'(rptr_nxt)));
      dout_q  <= rd_data_i;
    end
  end

  always_ff @(posedge rclk_i or negedge arst_n) begin
    if (!arst_n)     ov_q <= 1'b0;
    else if (!fwft_i) ov_q <= 1'b0;
    else if (pop)    ov_q <= 1'b1;
    else if (ren_i)  ov_q <= 1'b0;
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign dout_o  = dout_q;
  assign ef_or_o = fwft_i ? ~ov_q : has;
  assign pae_n_o = (rcnt > {1'b0, empty_ofs_i});

  // R5
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!arst_n)
    (!fwft_i && ren_i && !has) |=> ($stable(rptr_q) && $stable(dout_q)));

  // R3
  fwft_hold_chk: assert property (@(posedge rclk_i) disable iff (!arst_n)
    (fwft_i && ov_q && !ren_i) |=> (ov_q && $stable(dout_q)));

  // R7
  rcnt_range_chk: assert property (@(posedge rclk_i) disable iff (!arst_n)
    rcnt <= PW'(DEPTH));

endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter  int W           = 18,
  parameter  int DEPTH       = 1024,
  parameter  int DFLT_LO     = 127,
  parameter  int DFLT_HI     = 1023,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          fwft_i,
  input  logic          ld_sel_i,
  input  logic          wen_i,
  input  logic [W-1:0]  din_i,
  input  logic          ofs_wr_i,
  input  logic          ofs_sel_i,
  input  logic [AW-1:0] ofs_data_i,
  input  logic          ren_i,
  output logic [W-1:0]  dout_o,
  output logic          full_ir_o,
  output logic          ef_or_o,
  output logic          hf_n_o,
  output logic          paf_n_o,
  output logic          pae_n_o
);

  localparam int PW = AW + 1;

  logic          arst_n;
  logic [AW-1:0] waddr, raddr, empty_ofs;
  logic          mem_we;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  rd_data;

  assign arst_n = rst_ni & prst_ni;

  always_ff @(posedge wclk_i) begin
    if (mem_we) mem[waddr] <= din_i;
  end
  assign rd_data = mem[raddr];

  prog_fifo_wr #(
    .DEPTH(DEPTH), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)
  ) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .fwft_i(fwft_i),
    .ld_sel_i(ld_sel_i), .wen_i(wen_i), .ofs_wr_i(ofs_wr_i),
    .ofs_sel_i(ofs_sel_i), .ofs_data_i(ofs_data_i), .rgray_sync_i(rgray_sync),
    .waddr_o(waddr), .mem_we_o(mem_we), .wgray_o(wgray),
    .empty_ofs_o(empty_ofs), .full_ir_o(full_ir_o), .hf_n_o(hf_n_o),
    .paf_n_o(paf_n_o)
  );

  prog_fifo_rd #(.W(W), .DEPTH(DEPTH)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .prst_ni(prst_ni), .fwft_i(fwft_i),
    .ren_i(ren_i), .wgray_sync_i(wgray_sync), .empty_ofs_i(empty_ofs),
    .rd_data_i(rd_data), .raddr_o(raddr), .rgray_o(rgray), .dout_o(dout_o),
    .ef_or_o(ef_or_o), .pae_n_o(pae_n_o)
  );

  prog_fifo_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(arst_n), .d_i(wgray), .q_o(wgray_sync)
  );

  prog_fifo_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(arst_n), .d_i(rgray), .q_o(rgray_sync)
  );

endmodule

// File: tb/tb_prog_flag_fifo.sv
module tb_prog_flag_fifo;

  localparam int W = 18, DEPTH = 16, AW = 4, LO = 3, HI = 5;

  logic wclk = 0, rclk = 0, rst_n = 0, prst_n = 1, fwft = 0, ld_sel = 0;
  logic wen = 0, ren = 0, ofs_wr = 0, ofs_sel = 0;
  logic [W-1:0]  din = '0;
  logic [AW-1:0] ofs_data = '0;
  logic [W-1:0]  dout;
  logic full_ir, ef_or, hf_n, paf_n, pae_n;

  int nchk = 0, nfail = 0;
  int q[$];
  int last_rd = 0, m_ofs = LO, n_ofs = LO;

  prog_flag_fifo #(.W(W), .DEPTH(DEPTH), .DFLT_LO(LO), .DFLT_HI(HI)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n),
    .fwft_i(fwft), .ld_sel_i(ld_sel), .wen_i(wen), .din_i(din),
    .ofs_wr_i(ofs_wr), .ofs_sel_i(ofs_sel), .ofs_data_i(ofs_data),
    .ren_i(ren), .dout_o(dout), .full_ir_o(full_ir), .ef_or_o(ef_or),
    .hf_n_o(hf_n), .paf_n_o(paf_n), .pae_n_o(pae_n)
  );

  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int mem_cnt();
    if (fwft) return (q.size() > 0) ? q.size() - 1 : 0;
    return q.size();
  endfunction

  task automatic settle();
    repeat (8) @(posedge wclk);
    #3;
  endtask

  task automatic check_flags();
    int  c      = mem_cnt();
    logic full_e = (c == DEPTH);
    chk(fwft ? "R12" : "R4", "full/ir", full_ir, fwft ? full_e : !full_e);
    chk("R5", "empty/or", ef_or, fwft ? (q.size() == 0) : (c != 0));
    chk("R8", "half", hf_n, !(c > DEPTH / 2));
    chk("R6/R9", "paf", paf_n, !(c >= DEPTH - m_ofs));
    chk("R7/R9", "pae", pae_n, !(c <= n_ofs));
    if (fwft && q.size() > 0) chk("R3", "dout", dout, q[0]);
    else if (!fwft)           chk("R2", "dout", dout, last_rd);
  endtask

  task automatic write_word(int d);
    @(negedge wclk);
    wen = 1; din = W'(d);
    @(posedge wclk);
    #1 wen = 0;
    if (q.size() < (fwft ? DEPTH + 1 : DEPTH)) q.push_back(d);
  endtask

  task automatic read_word();
    @(negedge rclk);
    ren = 1;
    @(posedge rclk);
    #1 ren = 0;
    if (q.size() > 0) begin
      if (fwft) void'(q.pop_front());
      else      last_rd = q.pop_front();
    end
  endtask

  task automatic master_reset(logic ld, logic mode);
    rst_n = 0; fwft = mode; ld_sel = ld;
    repeat (3) @(posedge wclk);
    #3 rst_n = 1;
    q.delete(); last_rd = 0;
    m_ofs = ld ? HI : LO; n_ofs = ld ? HI : LO;
    settle();
  endtask

  task automatic load_ofs(logic sel, int v);
    @(negedge wclk);
    ofs_wr = 1; ofs_sel = sel; ofs_data = AW'(v);
    @(posedge wclk);
    #1 ofs_wr = 0;
    if (sel) n_ofs = v; else m_ofs = v;
  endtask

  initial begin
    #3000000;
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    // standard mode, low defaults
    master_reset(1'b0, 1'b0);
    chk("R1", "full", full_ir, 1); chk("R1", "empty", ef_or, 0);
    chk("R1", "half", hf_n, 1);    chk("R1", "paf", paf_n, 1);
    chk("R1", "pae", pae_n, 0);

    for (int i = 1; i <= DEPTH + 2; i++) begin
      write_word('h100 + i);
      settle();
      check_flags();
    end
    // R4: words beyond DEPTH were dropped; the reads below prove order and contents
    for (int i = 1; i <= DEPTH + 2; i++) begin
      read_word();
      settle();
      check_flags();
    end

    // R6: two-stage response of the almost-full flag
    for (int i = 0; i < DEPTH - m_ofs - 1; i++) write_word('h200 + i);
    settle();
    chk("R6", "paf below", paf_n, 1);
    write_word('h2ff);
    @(posedge wclk); #3 chk("R6", "paf edge1", paf_n, 1);
    @(posedge wclk); #3 chk("R6", "paf edge2", paf_n, 0);
    while (q.size() > 0) read_word();
    settle();
    check_flags();

    // R10: rewrite offsets
    load_ofs(1'b0, 6);
    load_ofs(1'b1, 8);
    settle();
    for (int i = 1; i <= DEPTH; i++) begin
      write_word('h300 + i);
      settle();
      check_flags();
      if (i == 8)  chk("R10", "pae at n", pae_n, 0);
      if (i == 9)  chk("R10", "pae at n+1", pae_n, 1);
      if (i == 9)  chk("R10", "paf below", paf_n, 1);
      if (i == 10) chk("R10", "paf at D-m", paf_n, 0);
    end

    // R11: partial reset keeps offsets
    @(negedge wclk); prst_n = 0;
    repeat (2) @(posedge wclk);
    #3 prst_n = 1;
    q.delete(); last_rd = 0;
    settle();
    chk("R11", "full", full_ir, 1); chk("R11", "empty", ef_or, 0);
    chk("R11", "paf", paf_n, 1);    chk("R11", "pae", pae_n, 0);
    chk("R11", "dout", dout, 0);
    for (int i = 1; i <= 10; i++) begin
      write_word('h400 + i);
      settle();
      check_flags();
      if (i == 4)  chk("R11", "pae kept", pae_n, 0);
      if (i == 10) chk("R11", "paf kept", paf_n, 0);
    end

    // fall-through mode, high defaults
    master_reset(1'b1, 1'b1);
    chk("R1", "ir", full_ir, 0); chk("R1", "or", ef_or, 1);
    chk("R1", "half", hf_n, 1);  chk("R1", "paf", paf_n, 1);
    chk("R1", "pae", pae_n, 0);
    read_word();
    settle();
    chk("R5", "read with no data", ef_or, 1);
    check_flags();

    for (int i = 1; i <= DEPTH + 3; i++) begin
      write_word('h500 + i);
      settle();
      check_flags();
      if (i == 1)  chk("R3", "first word shown", dout, 'h501);
      if (i == 6)  chk("R9", "pae at n", pae_n, 0);
      if (i == 7)  chk("R9", "pae at n+1", pae_n, 1);
      if (i == 11) chk("R12", "paf one early", paf_n, 1);
      if (i == 12) chk("R12", "paf at D+1-m", paf_n, 0);
      if (i == DEPTH)     chk("R12", "ir before last", full_ir, 0);
      if (i == DEPTH + 1) chk("R12", "ir at D+1", full_ir, 1);
    end
    for (int i = 1; i <= DEPTH + 3; i++) begin
      read_word();
      settle();
      check_flags();
    end
    chk("R5", "or after drain", ef_or, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule